// File: doc/BRIEF.md
# Configuration Bank Integrity Checker

This block scans one bank of non-volatile configuration storage and decides whether its contents can be trusted. After a start pulse it reads every byte of the bank once, in ascending address order, through a read port with one cycle of latency. While the bytes stream past, it runs three checks. The first byte must be the marker value. A one-byte header sum, with its carries folded back in, must match the stored header sum. A modular two-half running sum over the bank body must match the 32-bit value stored in the header.

When the scan ends, the block pulses `done`. If every check passed, it raises `valid` and reports the bank's 32-bit generation counter. If any check failed, both outputs are zero. A controller can scan two banks in turn and keep the one with the larger generation. Both results stay in place until the next start is accepted.

Top module: `nvbank_check`

## Requirements
- R1: After reset `done`, `valid` and `generation` are all 0.
- R2: A start accepted at a clock edge makes `done` high for exactly one cycle, after the BANK_BYTES+2-th following edge.
- R3: A start seen while a scan is in progress is ignored: the scan keeps its timing and result. During a scan, `rd_addr` steps up by one each cycle from 0 to BANK_BYTES-1.
- R4: The bank is invalid unless byte 0 equals 0x5A.
- R5: Header sum: start with byte 0 and add bytes 2 to 15 into a 16-bit sum. While the sum is above 0xFF, replace it with its low byte plus its high byte. The bank is invalid unless the result equals byte 1.
- R6: Body sum: over bytes 20 to BANK_BYTES-1, start a low half at 1 and a high half at 0. For each byte, low = (low + byte) mod 65521, then high = (high + low) mod 65521. The bank is invalid unless {high, low} equals the big-endian word in bytes 16..19, where byte 16 is the most significant.
- R7: When the bank is valid, `generation` is the big-endian word in bytes 20..23. Otherwise it is 0.
- R8: `valid` and `generation` hold their values after `done` until the next accepted start. Both clear to 0 at the edge that accepts it.
- R9: Byte 1 is not part of the header sum, and byte 0 is part of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| rd_addr | output | ADDR_W | Byte address presented to the bank memory |
| rd_data | input | 8 | Byte returned one cycle after its address |
| done | output | 1 | One-cycle pulse at the end of a scan |
| valid | output | 1 | Last scanned bank passed all checks |
| generation | output | 32 | Generation word of a valid bank, else 0 |

## Verification
The bench builds the block with BANK_BYTES set to 512 instead of 8192. A scan then takes about 500 cycles, so one run covers many banks. A body of 492 bytes of 0xFF still pushes the low half past 65521, so the modular wrap of both halves is exercised. A name field full of 0xFF forces the header sum through its carry fold. Corruptions placed only in the header, only at the last body byte, or only in the stored body sum separate each check from the others.

// File: rtl/nvbank_check.sv
module nvbank_check #(
  parameter int BANK_BYTES = 8192,
  parameter int ADDR_W = $clog2(BANK_BYTES),
  parameter logic [7:0] SIG_BYTE = 8'h5A,
  parameter int ADLER_MOD = 65521
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              valid,
  output logic [31:0]       generation
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BANK_BYTES - 1);
  localparam logic [16:0] MOD17 = 17'(ADLER_MOD);

  logic busy, iss, pend, fin;
  logic [ADDR_W-1:0] a, pa;
  logic [31:0] pi;
  logic sig_ok;
  logic [7:0] ck;
  logic [15:0] hsum;
  logic [31:0] adl_st, gen_st;
  logic [15:0] lo, hi, lo_nx, hi_nx;
  logic [16:0] lo_add, hi_add;
  logic [8:0] f1, f2;
  logic ok_now;

  assign rd_addr = a;
  assign pi = 32'(pa);

  assign lo_add = {1'b0, lo} + {9'b0, rd_data};
  assign lo_nx  = (lo_add >= MOD17) ? 16'(lo_add - MOD17) : lo_add[15:0];
  assign hi_add = {1'b0, hi} + {1'b0, lo_nx};
  assign hi_nx  = (hi_add >= MOD17) ? 16'(hi_add - MOD17) : hi_add[15:0];

  assign f1 = {1'b0, hsum[7:0]} + {1'b0, hsum[15:8]};
  assign f2 = {1'b0, f1[7:0]} + {8'b0, f1[8]};
  assign ok_now = sig_ok && (f2[7:0] == ck) && ({hi, lo} == adl_st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; iss <= 1'b0; pend <= 1'b0; fin <= 1'b0;
      a <= '0; pa <= '0;
      sig_ok <= 1'b0; ck <= '0; hsum <= '0;
      adl_st <= '0; gen_st <= '0;
      lo <= 16'd1; hi <= '0;
      done <= 1'b0; valid <= 1'b0; generation <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; iss <= 1'b1; a <= '0;
        valid <= 1'b0; generation <= '0;
        lo <= 16'd1; hi <= '0; hsum <= '0;
      end else if (iss) begin
        a <= a + 1'b1;
        if (a == LAST) iss <= 1'b0;
      end
      pend <= iss;
      pa   <= a;
      fin  <= pend && (pa == LAST);
      if (pend) begin
        if (pi == 0) begin
          sig_ok <= (rd_data == SIG_BYTE);
          hsum   <= {8'b0, rd_data};
        end else if (pi == 1) begin
          ck <= rd_data;
        end else if (pi <= 15) begin
          hsum <= hsum + {8'b0, rd_data};
        end else if (pi <= 19) begin
          adl_st <= {adl_st[23:0], rd_data};
        end
        if (pi >= 20) begin
          lo <= lo_nx;
          hi <= hi_nx;
        end
        if (pi >= 20 && pi <= 23) gen_st <= {gen_st[23:0], rd_data};
      end
      if (fin) begin
        busy <= 1'b0;
        done <= 1'b1;
        valid <= ok_now;
        generation <= ok_now ? gen_st : 32'd0;
      end
    end
  end
endmodule

module nvbank_check_sva #(
  parameter int ADDR_W = 13,
  parameter int ADLER_MOD = 65521
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              done,
  input logic              valid,
  input logic [31:0]       generation,
  input logic              iss,
  input logic [15:0]       lo,
  input logic [15:0]       hi
);
  localparam logic [15:0] M16 = 16'(ADLER_MOD);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !valid) |-> (generation == 32'd0));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(valid) || !$stable(generation)) |-> (done || $past(start)));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && $past(iss)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo < M16) && (hi < M16));
endmodule

bind nvbank_check nvbank_check_sva #(.ADDR_W(ADDR_W), .ADLER_MOD(ADLER_MOD)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr), .done(done),
  .valid(valid), .generation(generation), .iss(iss), .lo(lo), .hi(hi)
);

// File: tb/nvbank_check_test.sv
module nvbank_check_test;
  localparam int CLK_P = 10;
  localparam int N = 512;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic done, valid;
  logic [31:0] generation;
  logic [7:0] mem [0:N-1];
  int total = 0, bad = 0;
  bit ended = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) rd_data <= mem[rd_addr];

  nvbank_check #(.BANK_BYTES(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .valid(valid), .generation(generation));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hdr();
    int s = mem[0];
    for (int i = 2; i <= 15; i++) s += mem[i];
    while (s > 255) s = (s & 255) + (s >> 8);
    return 8'(s);
  endfunction

  function automatic logic [31:0] ref_body();
    int lo = 1, hi = 0;
    for (int i = 20; i < N; i++) begin
      lo = (lo + mem[i]) % 65521;
      hi = (hi + lo) % 65521;
    end
    return {hi[15:0], lo[15:0]};
  endfunction

  task automatic fill(input int kind);
    for (int i = 0; i < N; i++)
      case (kind)
        0: mem[i] = 8'(i * 7 + 3);
        1: mem[i] = 8'hFF;
        2: mem[i] = 8'h00;
        default: mem[i] = (i >= 2 && i <= 15) ? 8'hFF : 8'(i ^ 8'h5C);
      endcase
  endtask

  task automatic seal(input logic [7:0] sig, input logic [31:0] gen);
    logic [31:0] s;
    mem[0] = sig;
    for (int i = 0; i < 4; i++) mem[20+i] = gen[31-8*i -: 8];
    mem[1] = ref_hdr();
    s = ref_body();
    for (int i = 0; i < 4; i++) mem[16+i] = s[31-8*i -: 8];
  endtask

  task automatic run_bank(input string req, input bit exp_v, input logic [31:0] exp_g,
                          input int extra_start);
    int cyc = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (cyc < N + 50) begin
      @(negedge clk);
      cyc++;
      start = (cyc == extra_start);
      if (done) break;
    end
    start = 1'b0;
    chk(cyc == N + 2, "R2", "done latency", 32'(cyc), 32'(N + 2));
    chk(valid == exp_v, req, "valid", 32'(valid), 32'(exp_v));
    chk(generation == exp_g, req, "generation", generation, exp_g);
    @(negedge clk);
    chk(!done, "R2", "done single cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk(!done && !valid && generation == 0, "R1", "reset outputs",
        {valid, done, generation[29:0]}, 32'd0);
  endtask

  task automatic t_good(input int kind, input logic [31:0] g);
    fill(kind); seal(8'h5A, g);
    run_bank("R6 R7", 1'b1, g, 0);
  endtask

  task automatic t_fold();
    fill(3); seal(8'h5A, 32'h0BAD_F00D);
    run_bank("R5 R9", 1'b1, 32'h0BAD_F00D, 0);
  endtask

  task automatic t_bad_sig();
    fill(0); seal(8'h5B, 32'h1111_2222);
    run_bank("R4", 1'b0, 32'd0, 0);
  endtask

  task automatic t_bad_hdr();
    fill(0); seal(8'h5A, 32'h3333_4444);
    mem[3] ^= 8'h01;
    run_bank("R5", 1'b0, 32'd0, 0);
  endtask

  task automatic t_bad_body();
    fill(0); seal(8'h5A, 32'h5555_6666);
    mem[N-1] ^= 8'h40;
    run_bank("R6", 1'b0, 32'd0, 0);
  endtask

  task automatic t_bad_stored();
    fill(2); seal(8'h5A, 32'h7777_8888);
    mem[19] ^= 8'h01;
    run_bank("R6", 1'b0, 32'd0, 0);
  endtask

  task automatic t_hold();
    fill(0); seal(8'h5A, 32'hCAFE_0042);
    run_bank("R7", 1'b1, 32'hCAFE_0042, 0);
    fill(1);
    repeat (30) @(negedge clk);
    chk(valid && generation == 32'hCAFE_0042, "R8", "hold after done",
        generation, 32'hCAFE_0042);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!valid && generation == 0, "R8", "clear on start", generation, 32'd0);
    while (!done) @(negedge clk);
    chk(!valid && generation == 0, "R8", "bad bank after hold", generation, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_restart();
    fill(0); seal(8'h5A, 32'h0000_0099);
    run_bank("R3", 1'b1, 32'h0000_0099, 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fill(2);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good(0, 32'h0000_0007);
    t_good(1, 32'h1234_5678);
    t_good(2, 32'h0000_00A5);
    t_fold();
    t_bad_sig();
    t_bad_hdr();
    t_bad_body();
    t_bad_stored();
    t_hold();
    t_restart();
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule